// File: doc/BRIEF.md
# Split-Bus / Packet-Link Command Translator

This block translates transaction descriptors between a split-transaction parallel bus and a packetised point-to-point link, one direction in each half. Toward the link, it takes a bus transaction class together with its relaxed-ordering bit, snoop indication, error flags and the parity-error-response setting. It produces a link command with its posted, may-pass-posted, response-may-pass-posted, coherent and data-error attributes. When the error rules say the write must be thrown away, it produces a discard pulse instead. Toward the bus, it takes a link command, the target address space and the may-pass-posted bit, and produces a bus transaction class with relaxed-ordering and no-snoop attributes.

Each direction is one registered valid/ready stage, so the two directions run independently. An input class or command that the block does not recognise is consumed. It produces no output transaction and raises a one-cycle error pulse on that direction. The asynchronous active-low reset is released to the flops through a two-stage synchroniser.

Top module: `cmd_xlate`

## Requirements
- R1: After reset, both output valids, all discard and error pulses are low and both input readies are high.
- R2: Bus class 0 (posted memory write) becomes link command 0 (sized write) with posted=1, may-pass equal to the relaxed bit, response-may-pass=0, coherent=0 and data-error equal to the detected error.
- R3: Bus class 1 (split read request) becomes link command 1 (sized read) with posted=0, may-pass=0, response-may-pass equal to the relaxed bit, coherent equal to the snoop flag and data-error=0.
- R4: Bus class 2 (split write request) becomes link command 0 with posted=0, may-pass=0 and data-error equal to the detected error. When the detected error and the response-enable input are both 1, it produces no output and pulses the toward-link discard output once.
- R5: Bus class 3 (split read completion) becomes link command 2 (read response) with may-pass equal to the relaxed bit and data-error equal to the detected error.
- R6: Bus class 4 (split write completion) becomes link command 3 (target done) with may-pass=0, posted=0 and data-error equal to the detected error. When the detected error and the response-enable input are both 1, it is discarded as in R4.
- R7: The detected error is the parity-error input OR (ECC-mode AND uncorrectable-ECC); an uncorrectable ECC flag outside ECC mode has no effect.
- R8: Link command 0 to space 0 (memory) becomes bus class 0. To space 1 (I/O) or space 2 (configuration) it becomes bus class 2. To space 3 it is unrecognised as in R11.
- R9: Link command 1 becomes bus class 1, command 2 becomes bus class 3 with relaxed equal to the may-pass bit, and command 3 becomes bus class 4. The space input has no effect on these commands.
- R10: Toward the bus, relaxed is 0 for every class except 3, and no-snoop is always 0.
- R11: Bus classes 5 to 7 and link commands 4 to 7 give no output transaction and exactly one error pulse, in the cycle after the input handshake. Discard and error never pulse together.
- R12: An output held while its ready is low keeps its valid and all its attributes unchanged. Results leave each direction in the order their inputs were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bi_valid | input | 1 | Bus-side descriptor valid (toward link) |
| bi_ready | output | 1 | Bus-side descriptor accepted |
| bi_class | input | 3 | Bus transaction class |
| bi_relaxed | input | 1 | Relaxed-ordering bit |
| bi_snoop | input | 1 | Snoop indication |
| bi_par_err | input | 1 | Data parity error detected |
| bi_ecc_mode | input | 1 | ECC operating mode |
| bi_ecc_uncorr | input | 1 | Uncorrectable ECC error detected |
| bi_perr_resp_en | input | 1 | Parity-error-response enable |
| lo_valid | output | 1 | Link command valid |
| lo_ready | input | 1 | Link command accepted |
| lo_cmd | output | 3 | Link command type |
| lo_posted | output | 1 | Posted attribute |
| lo_may_pass | output | 1 | May pass posted writes |
| lo_rsp_may_pass | output | 1 | Response may pass posted writes |
| lo_coherent | output | 1 | Coherent (snooped) access |
| lo_data_err | output | 1 | Data-error attribute |
| lo_drop | output | 1 | One-cycle pulse: write discarded |
| lo_bad | output | 1 | One-cycle pulse: unrecognised bus class |
| li_valid | input | 1 | Link-side command valid (toward bus) |
| li_ready | output | 1 | Link-side command accepted |
| li_cmd | input | 3 | Link command type |
| li_space | input | 2 | Target address space |
| li_may_pass | input | 1 | May-pass-posted bit of the command |
| bo_valid | output | 1 | Bus transaction valid |
| bo_ready | input | 1 | Bus transaction accepted |
| bo_class | output | 3 | Bus transaction class |
| bo_relaxed | output | 1 | Relaxed-ordering attribute |
| bo_no_snoop | output | 1 | No-snoop attribute |
| bo_bad | output | 1 | One-cycle pulse: unrecognised link command |

## Verification
The properties assume that each producer holds its descriptor steady from the cycle it raises valid until the cycle ready is seen high. They also assume that an error pulse can only follow a real input handshake. The stimulus drives each descriptor at a falling edge and keeps it unchanged until ready is observed high at a falling edge, then replaces it. The output readies are toggled from a pseudo-random pattern, so the hold properties are exercised under back-pressure as well as under free flow. The sweeps cover every class or command code, including the unrecognised ones, with every combination of the attribute inputs.

// File: rtl/cmd_xlate_pkg.sv
package cmd_xlate_pkg;
  localparam int CLS_W = 3;
  localparam int CMD_W = 3;
  localparam int SPC_W = 2;

  // bus transaction classes
  localparam logic [CLS_W-1:0] CLS_PWR   = 3'd0;
  localparam logic [CLS_W-1:0] CLS_RDREQ = 3'd1;
  localparam logic [CLS_W-1:0] CLS_WRREQ = 3'd2;
  localparam logic [CLS_W-1:0] CLS_RDCPL = 3'd3;
  localparam logic [CLS_W-1:0] CLS_WRCPL = 3'd4;

  // link command types
  localparam logic [CMD_W-1:0] CMD_WR   = 3'd0;
  localparam logic [CMD_W-1:0] CMD_RD   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_RESP = 3'd2;
  localparam logic [CMD_W-1:0] CMD_DONE = 3'd3;

  // address spaces
  localparam logic [SPC_W-1:0] SPC_MEM = 2'd0;
  localparam logic [SPC_W-1:0] SPC_IO  = 2'd1;
  localparam logic [SPC_W-1:0] SPC_CFG = 2'd2;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             posted;
    logic             may_pass;
    logic             rsp_may_pass;
    logic             coherent;
    logic             data_err;
  } link_pkt_t;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic             relaxed;
    logic             no_snoop;
  } bus_txn_t;
endpackage

// File: rtl/xlate_rst_sync.sv
module xlate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/xlate_b2l_map.sv
module xlate_b2l_map
  import cmd_xlate_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             relaxed,
  input  logic             snoop,
  input  logic             par_err,
  input  logic             ecc_mode,
  input  logic             ecc_uncorr,
  input  logic             perr_resp_en,
  output link_pkt_t        pkt,
  output logic             keep,
  output logic             bad,
  output logic             drop
);
  logic derr;

  always_comb begin
    derr = par_err | (ecc_mode & ecc_uncorr);
    pkt  = '0;
    keep = 1'b1;
    bad  = 1'b0;
    drop = 1'b0;
    case (cls)
      CLS_PWR: begin
        pkt.cmd      = CMD_WR;
        pkt.posted   = 1'b1;
        pkt.may_pass = relaxed;
        pkt.data_err = derr;
      end
      CLS_RDREQ: begin
        pkt.cmd          = CMD_RD;
        pkt.rsp_may_pass = relaxed;
        pkt.coherent     = snoop;
      end
      CLS_WRREQ: begin
        pkt.cmd      = CMD_WR;
        pkt.data_err = derr;
        drop         = derr & perr_resp_en;
      end
      CLS_RDCPL: begin
        pkt.cmd      = CMD_RESP;
        pkt.may_pass = relaxed;
        pkt.data_err = derr;
      end
      CLS_WRCPL: begin
        pkt.cmd      = CMD_DONE;
        pkt.data_err = derr;
        drop         = derr & perr_resp_en;
      end
      default: bad = 1'b1;
    endcase
    if (bad || drop) keep = 1'b0;
  end
endmodule

// File: rtl/xlate_l2b_map.sv
module xlate_l2b_map
  import cmd_xlate_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic [SPC_W-1:0] space,
  input  logic             may_pass,
  output bus_txn_t         txn,
  output logic             keep,
  output logic             bad
);
  always_comb begin
    txn  = '0;   // requests never relaxed, no-snoop always clear
    bad  = 1'b0;
    case (cmd)
      CMD_WR: begin
        if (space == SPC_MEM)                       txn.cls = CLS_PWR;
        else if (space == SPC_IO || space == SPC_CFG) txn.cls = CLS_WRREQ;
        else                                        bad = 1'b1;
      end
      CMD_RD:   txn.cls = CLS_RDREQ;
      CMD_RESP: begin
        txn.cls     = CLS_RDCPL;
        txn.relaxed = may_pass;
      end
      CMD_DONE: txn.cls = CLS_WRCPL;
      default:  bad = 1'b1;
    endcase
    keep = !bad;
  end
endmodule

// File: rtl/xlate_stage.sv
module xlate_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_keep,
  input  logic         in_bad,
  input  logic         in_drop,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_bad,
  output logic         out_drop
);
  logic         vld_q, vld_d;
  logic         bad_q, bad_d;
  logic         drop_q, drop_d;
  logic [W-1:0] dat_q;
  logic         acc, load_en;

  always_comb begin
    in_ready = !vld_q || out_ready;
    acc      = in_valid && in_ready;
    load_en  = acc && in_keep;
    vld_d    = acc ? in_keep : (vld_q && !out_ready);
    bad_d    = acc && in_bad;
    drop_d   = acc && in_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      bad_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      bad_q  <= bad_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_bad   = bad_q;
  assign out_drop  = drop_q;
endmodule

// File: rtl/cmd_xlate.sv
module cmd_xlate
  import cmd_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bi_valid,
  output logic             bi_ready,
  input  logic [CLS_W-1:0] bi_class,
  input  logic             bi_relaxed,
  input  logic             bi_snoop,
  input  logic             bi_par_err,
  input  logic             bi_ecc_mode,
  input  logic             bi_ecc_uncorr,
  input  logic             bi_perr_resp_en,
  output logic             lo_valid,
  input  logic             lo_ready,
  output logic [CMD_W-1:0] lo_cmd,
  output logic             lo_posted,
  output logic             lo_may_pass,
  output logic             lo_rsp_may_pass,
  output logic             lo_coherent,
  output logic             lo_data_err,
  output logic             lo_drop,
  output logic             lo_bad,
  input  logic             li_valid,
  output logic             li_ready,
  input  logic [CMD_W-1:0] li_cmd,
  input  logic [SPC_W-1:0] li_space,
  input  logic             li_may_pass,
  output logic             bo_valid,
  input  logic             bo_ready,
  output logic [CLS_W-1:0] bo_class,
  output logic             bo_relaxed,
  output logic             bo_no_snoop,
  output logic             bo_bad
);
  localparam int PKT_W = $bits(link_pkt_t);
  localparam int TXN_W = $bits(bus_txn_t);

  logic      rst_n_s;
  link_pkt_t b2l_pkt, lo_pkt;
  bus_txn_t  l2b_txn, bo_txn;
  logic      b2l_keep, b2l_bad, b2l_drop;
  logic      l2b_keep, l2b_bad;
  logic      bo_drop_unused;

  xlate_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  xlate_b2l_map u_b2l_map (
    .cls(bi_class), .relaxed(bi_relaxed), .snoop(bi_snoop),
    .par_err(bi_par_err), .ecc_mode(bi_ecc_mode), .ecc_uncorr(bi_ecc_uncorr),
    .perr_resp_en(bi_perr_resp_en),
    .pkt(b2l_pkt), .keep(b2l_keep), .bad(b2l_bad), .drop(b2l_drop)
  );

  xlate_stage #(.W(PKT_W)) u_b2l_stage (
    .clk(clk), .rst_n(rst_n_s),
    .in_valid(bi_valid), .in_ready(bi_ready), .in_data(b2l_pkt),
    .in_keep(b2l_keep), .in_bad(b2l_bad), .in_drop(b2l_drop),
    .out_valid(lo_valid), .out_ready(lo_ready), .out_data(lo_pkt),
    .out_bad(lo_bad), .out_drop(lo_drop)
  );

  xlate_l2b_map u_l2b_map (
    .cmd(li_cmd), .space(li_space), .may_pass(li_may_pass),
    .txn(l2b_txn), .keep(l2b_keep), .bad(l2b_bad)
  );

  xlate_stage #(.W(TXN_W)) u_l2b_stage (
    .clk(clk), .rst_n(rst_n_s),
    .in_valid(li_valid), .in_ready(li_ready), .in_data(l2b_txn),
    .in_keep(l2b_keep), .in_bad(l2b_bad), .in_drop(1'b0),
    .out_valid(bo_valid), .out_ready(bo_ready), .out_data(bo_txn),
    .out_bad(bo_bad), .out_drop(bo_drop_unused)
  );

  assign lo_cmd          = lo_pkt.cmd;
  assign lo_posted       = lo_pkt.posted;
  assign lo_may_pass     = lo_pkt.may_pass;
  assign lo_rsp_may_pass = lo_pkt.rsp_may_pass;
  assign lo_coherent     = lo_pkt.coherent;
  assign lo_data_err     = lo_pkt.data_err;
  assign bo_class        = bo_txn.cls;
  assign bo_relaxed      = bo_txn.relaxed;
  assign bo_no_snoop     = bo_txn.no_snoop;
endmodule

// File: rtl/cmd_xlate_chk.sv
module cmd_xlate_chk
  import cmd_xlate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bi_valid,
  input logic             bi_ready,
  input logic             lo_valid,
  input logic             lo_ready,
  input logic [CMD_W-1:0] lo_cmd,
  input logic             lo_posted,
  input logic             lo_may_pass,
  input logic             lo_rsp_may_pass,
  input logic             lo_coherent,
  input logic             lo_data_err,
  input logic             lo_drop,
  input logic             lo_bad,
  input logic             li_valid,
  input logic             li_ready,
  input logic             bo_valid,
  input logic             bo_ready,
  input logic [CLS_W-1:0] bo_class,
  input logic             bo_relaxed,
  input logic             bo_no_snoop,
  input logic             bo_bad
);
  p_lo_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid && !lo_ready |=> lo_valid &&
      $stable({lo_cmd, lo_posted, lo_may_pass, lo_rsp_may_pass, lo_coherent, lo_data_err}));

  p_bo_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bo_valid && !bo_ready |=> bo_valid && $stable({bo_class, bo_relaxed, bo_no_snoop}));

  p_posted_is_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid && lo_posted |-> lo_cmd == CMD_WR && !lo_rsp_may_pass && !lo_coherent);

  p_read_no_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid && lo_cmd == CMD_RD |-> !lo_posted && !lo_may_pass && !lo_data_err);

  p_done_no_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid && lo_cmd == CMD_DONE |-> !lo_may_pass && !lo_posted);

  p_req_not_relaxed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bo_valid && bo_class != CLS_RDCPL |-> !bo_relaxed);

  p_no_snoop_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bo_valid |-> !bo_no_snoop);

  p_bad_drop_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_bad && lo_drop));

  p_lo_bad_after_hs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lo_bad |-> $past(bi_valid && bi_ready));

  p_bo_bad_after_hs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bo_bad |-> $past(li_valid && li_ready));
endmodule

bind cmd_xlate cmd_xlate_chk u_chk (.*);

// File: tb/cmd_xlate_bench.sv
`timescale 1ns/1ps
module cmd_xlate_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bi_valid, bi_ready;
  logic [2:0] bi_class;
  logic       bi_relaxed, bi_snoop, bi_par_err, bi_ecc_mode, bi_ecc_uncorr, bi_perr_resp_en;
  logic       lo_valid, lo_ready;
  logic [2:0] lo_cmd;
  logic       lo_posted, lo_may_pass, lo_rsp_may_pass, lo_coherent, lo_data_err, lo_drop, lo_bad;
  logic       li_valid, li_ready;
  logic [2:0] li_cmd;
  logic [1:0] li_space;
  logic       li_may_pass;
  logic       bo_valid, bo_ready;
  logic [2:0] bo_class;
  logic       bo_relaxed, bo_no_snoop, bo_bad;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit stall = 0;

  // expected events: {kind[1:0], payload[7:0]}; kind 0=output 1=discard 2=error
  logic [9:0] exp_l[$];
  string      tag_l[$];
  logic [9:0] exp_b[$];
  string      tag_b[$];

  always #2.5 clk = ~clk;

  cmd_xlate u_cmd_xlate (.*);

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // back-pressure generator
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    lo_ready <= stall ? lfsr[0] : 1'b1;
    bo_ready <= stall ? lfsr[3] : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (lo_valid && lo_ready)
        pop_l({2'd0, lo_cmd, lo_posted, lo_may_pass, lo_rsp_may_pass, lo_coherent, lo_data_err});
      if (lo_drop) pop_l({2'd1, 8'd0});
      if (lo_bad)  pop_l({2'd2, 8'd0});
      if (bo_valid && bo_ready) pop_b({2'd0, 3'd0, bo_class, bo_relaxed, bo_no_snoop});
      if (bo_bad) pop_b({2'd2, 8'd0});
    end
  end

  task automatic pop_l(logic [9:0] act);
    if (exp_l.size() == 0) check("R12 unexpected link-side event", act, 10'h3FF);
    else check(tag_l.pop_front(), act, exp_l.pop_front());
  endtask

  task automatic pop_b(logic [9:0] act);
    if (exp_b.size() == 0) check("R12 unexpected bus-side event", act, 10'h3FF);
    else check(tag_b.pop_front(), act, exp_b.pop_front());
  endtask

  // bus -> link driver
  task automatic send_b2l(logic [2:0] c, logic ro, logic sn, logic pe, logic em, logic eu, logic en);
    logic err;
    logic [9:0] e;
    string t;
    err = pe || (em && eu);
    t = (!pe && eu) ? "R7" : "R2";
    if (c == 3'd0)      e = {2'd0, 3'd0, 1'b1, ro, 1'b0, 1'b0, err};
    else if (c == 3'd1) begin e = {2'd0, 3'd1, 1'b0, 1'b0, ro, sn, 1'b0}; t = {t, " R3"}; end
    else if (c == 3'd2) begin
      e = (err && en) ? {2'd1, 8'd0} : {2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, err};
      t = {t, " R4"};
    end
    else if (c == 3'd3) begin e = {2'd0, 3'd2, 1'b0, ro, 1'b0, 1'b0, err}; t = {t, " R5"}; end
    else if (c == 3'd4) begin
      e = (err && en) ? {2'd1, 8'd0} : {2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, err};
      t = {t, " R6"};
    end
    else begin e = {2'd2, 8'd0}; t = "R11 bus class"; end
    @(negedge clk);
    exp_l.push_back(e);
    tag_l.push_back(t);
    bi_valid = 1'b1; bi_class = c; bi_relaxed = ro; bi_snoop = sn;
    bi_par_err = pe; bi_ecc_mode = em; bi_ecc_uncorr = eu; bi_perr_resp_en = en;
    while (!bi_ready) @(negedge clk);
  endtask

  // link -> bus driver
  task automatic send_l2b(logic [2:0] c, logic [1:0] sp, logic mp);
    logic [9:0] e;
    string t;
    if (c == 3'd0 && sp == 2'd0)      begin e = {2'd0, 3'd0, 3'd0, 1'b0, 1'b0}; t = "R8 R10"; end
    else if (c == 3'd0 && sp != 2'd3) begin e = {2'd0, 3'd0, 3'd2, 1'b0, 1'b0}; t = "R8 R10"; end
    else if (c == 3'd1)               begin e = {2'd0, 3'd0, 3'd1, 1'b0, 1'b0}; t = "R9 R10"; end
    else if (c == 3'd2)               begin e = {2'd0, 3'd0, 3'd3, mp, 1'b0};   t = "R9"; end
    else if (c == 3'd3)               begin e = {2'd0, 3'd0, 3'd4, 1'b0, 1'b0}; t = "R9 R10"; end
    else                              begin e = {2'd2, 8'd0}; t = "R11 R8 link command"; end
    @(negedge clk);
    exp_b.push_back(e);
    tag_b.push_back(t);
    li_valid = 1'b1; li_cmd = c; li_space = sp; li_may_pass = mp;
    while (!li_ready) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    bi_valid = 0; bi_class = 0; bi_relaxed = 0; bi_snoop = 0; bi_par_err = 0;
    bi_ecc_mode = 0; bi_ecc_uncorr = 0; bi_perr_resp_en = 0;
    li_valid = 0; li_cmd = 0; li_space = 0; li_may_pass = 0;
    lo_ready = 1; bo_ready = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {6'd0, lo_valid, bo_valid, lo_bad, lo_drop, bo_bad, bi_ready, li_ready},
          {6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});

    // directed corner cases
    send_b2l(3'd0, 1, 0, 0, 0, 0, 0);
    send_b2l(3'd1, 1, 1, 0, 0, 0, 0);
    send_b2l(3'd2, 0, 0, 1, 0, 0, 1);  // discard
    send_b2l(3'd4, 0, 0, 0, 1, 1, 1);  // ECC error, discard
    send_b2l(3'd3, 1, 0, 0, 0, 1, 0);  // ECC flag outside ECC mode ignored
    send_b2l(3'd6, 0, 0, 0, 0, 0, 0);  // unrecognised
    @(negedge clk) bi_valid = 0;
    send_l2b(3'd0, 2'd3, 1);
    send_l2b(3'd2, 2'd3, 1);
    @(negedge clk) li_valid = 0;

    for (int pass = 0; pass < 2; pass++) begin
      stall = (pass == 1);
      fork
        begin
          for (int c = 0; c < 8; c++)
            for (int b = 0; b < 64; b++)
              send_b2l(c[2:0], b[0], b[1], b[2], b[3], b[4], b[5]);
          @(negedge clk) bi_valid = 0;
        end
        begin
          for (int c = 0; c < 8; c++)
            for (int b = 0; b < 8; b++)
              send_l2b(c[2:0], b[1:0], b[2]);
          @(negedge clk) li_valid = 0;
        end
      join
    end

    stall = 0;
    repeat (40) @(negedge clk);
    check("R12 link-side results outstanding", 10'(exp_l.size()), 10'd0);
    check("R12 bus-side results outstanding", 10'(exp_b.size()), 10'd0);
    summary();
  end
endmodule